// File: doc/BRIEF.md
# Power-Up Offset Calibration Sequencer

This block sits in the digital output path of a two-channel 24-bit converter. It runs the offset calibration that follows power-up. When the active-low reset is released, the block counts sample strobes for a fixed calibration window. It averages the last 256 raw samples of each channel in that window and keeps the result as that channel's offset. After that, every raw sample is passed on with its offset subtracted, and the result is clamped to the signed 24-bit range.

The length of the window depends on two static inputs. A rate select doubles both the busy length and the data-valid delay. A slave flag adds one sample period to each. A source-select input states whether calibration should measure the signal inputs or the common-mode reference. During calibration, the block drives a steering output toward the analog front end from that input. Pulling reset low at any time abandons the cycle. The block then sits idle until reset is released again.

Top module: `ocal_seq`

## Requirements
- R1: While rst_ni is low, busy_o, valid_o, cm_sel_o, out_l_o and out_r_o are all zero, whatever the other inputs are.
- R2: busy_o rises on the first clock edge after rst_ni goes high. Strobes are counted only from the edge after that one.
- R3: With dbl_rate_i=0 and slave_i=0, busy_o falls after the 8704th counted strobe, and valid_o rises after the 8960th.
- R4: With dbl_rate_i=1, the two counts are 17408 and 17920.
- R5: With slave_i=1, each count is one strobe longer than with slave_i=0, at either rate.
- R6: Each channel's offset is the floor of the mean of its samples on the last 256 counted strobes up to and including the one that ends busy. Earlier samples have no effect on it.
- R7: out_l_o and out_r_o stay zero until valid_o rises. From the strobe that raises valid_o onward, each strobe loads raw minus offset, and the outputs hold between strobes. valid_o stays high until reset.
- R8: When raw minus offset is above 7FFFFF hex, the output is 7FFFFF hex. When it is below -800000 hex, the output is 800000 hex. Both values are read as two's complement.
- R9: cm_sel_o is high exactly while busy_o is high and cal_sig_i is low. A high cm_sel_o selects the common-mode reference; a low one selects the signal inputs.
- R10: Pulling rst_ni low in mid-calibration clears busy_o at once. After release, the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its release starts calibration |
| stb_i | input | 1 | One-cycle sample strobe, one per sample period |
| dbl_rate_i | input | 1 | Double-rate select (static) |
| slave_i | input | 1 | Slave-mode flag (static) |
| cal_sig_i | input | 1 | Calibration source: 1 signal inputs, 0 common-mode reference |
| raw_l_i | input | 24 | Left raw sample, two's complement |
| raw_r_i | input | 24 | Right raw sample, two's complement |
| cm_sel_o | output | 1 | Steers the front end to the common-mode reference |
| busy_o | output | 1 | Calibration in progress |
| valid_o | output | 1 | Corrected data valid |
| out_l_o | output | 24 | Left corrected sample |
| out_r_o | output | 24 | Right corrected sample |

## Verification
A strobe counter that is off by one moves the falling edge of busy_o or the rising edge of valid_o by exactly one strobe. The bench compares each run against the limits for its rate and mode, so such an error shows within a single calibration. A wrong averaging window or wrong shift leaves a wrong offset. That offset appears as a constant error on the first valid output word, because the samples before the window are set to large values that would distort the mean. A missing clamp wraps the sign of a near-full-scale word on the first strobe that pushes it past a limit.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  localparam int SMP_W = 24;

  function automatic logic [SMP_W-1:0] sat_sub(input logic [SMP_W-1:0] a,
                                                input logic [SMP_W-1:0] b);
    logic [SMP_W:0] d;
    d = {a[SMP_W-1], a} - {b[SMP_W-1], b};
    if (d[SMP_W] != d[SMP_W-1])
      return d[SMP_W] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
    return d[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/ocal_timer.sv
module ocal_timer #(
  parameter int BUSY_BASE  = 8704,
  parameter int VALID_BASE = 8960,
  parameter int AVG_N      = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic dbl_i,
  input  logic slave_i,
  output logic busy_o,
  output logic valid_o,
  output logic acc_en_o,
  output logic latch_o,
  output logic load_o
);
  localparam int CNT_W = $clog2(2*VALID_BASE + 2);

  logic             armed_q, done_q, valid_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, busy_lim, valid_lim, win_lo;
  logic             tick, hit_busy, hit_valid;

  always_comb begin
    busy_lim  = (dbl_i ? CNT_W'(2*BUSY_BASE) : CNT_W'(BUSY_BASE))
                + {{(CNT_W-1){1'b0}}, slave_i};
    valid_lim = (dbl_i ? CNT_W'(2*VALID_BASE) : CNT_W'(VALID_BASE))
                + {{(CNT_W-1){1'b0}}, slave_i};
    win_lo    = busy_lim - CNT_W'(AVG_N);
    cnt_nxt   = cnt_q + CNT_W'(1);
    tick      = stb_i & armed_q & ~valid_q;
    hit_busy  = tick & ~done_q & (cnt_nxt == busy_lim);
    hit_valid = tick & (cnt_nxt == valid_lim);
  end

  assign acc_en_o = tick & ~done_q & (cnt_nxt > win_lo);
  assign latch_o  = hit_busy;
  assign load_o   = stb_i & (valid_q | hit_valid);
  assign busy_o   = armed_q & ~done_q;
  assign valid_o  = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= 1'b1;
      if (tick)      cnt_q   <= cnt_nxt;
      if (hit_busy)  done_q  <= 1'b1;
      if (hit_valid) valid_q <= 1'b1;
    end
  end

  // R7
  valid_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
  // R7
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  // R3
  busy_fall_on_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(stb_i));
  // R3
  valid_rise_on_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(stb_i));
endmodule

// File: rtl/ocal_chan.sv
module ocal_chan
  import ocal_pkg::*;
#(
  parameter int AVG_N = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] raw_i,
  input  logic             acc_en_i,
  input  logic             latch_i,
  input  logic             load_i,
  input  logic             hold_i,
  output logic [SMP_W-1:0] out_o
);
  localparam int AVG_LOG = $clog2(AVG_N);
  localparam int ACC_W   = SMP_W + AVG_LOG;

  logic [ACC_W-1:0] acc_q, raw_ext, sum;
  logic [SMP_W-1:0] off_q, out_q;

  assign raw_ext = {{(ACC_W-SMP_W){raw_i[SMP_W-1]}}, raw_i};
  assign sum     = acc_q + raw_ext;
  assign out_o   = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      off_q <= '0;
      out_q <= '0;
    end else begin
      if (acc_en_i) acc_q <= sum;
      // arithmetic shift: keep the top SMP_W bits of the sum
      if (latch_i)  off_q <= sum[ACC_W-1:AVG_LOG];
      if (load_i)   out_q <= sat_sub(raw_i, off_q);
    end
  end

  // R6
  offset_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(off_q));
  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(out_q));
  // R7
  out_zero_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !load_i) |=> (out_q == '0));
endmodule

// File: rtl/ocal_seq.sv
module ocal_seq
  import ocal_pkg::*;
#(
  parameter int BUSY_BASE  = 8704,
  parameter int VALID_BASE = 8960,
  parameter int AVG_N      = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             dbl_rate_i,
  input  logic             slave_i,
  input  logic             cal_sig_i,
  input  logic [SMP_W-1:0] raw_l_i,
  input  logic [SMP_W-1:0] raw_r_i,
  output logic             cm_sel_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [SMP_W-1:0] out_l_o,
  output logic [SMP_W-1:0] out_r_o
);
  localparam int N_CH = 2;

  logic             busy, valid, acc_en, latch, load;
  logic [SMP_W-1:0] raw [N_CH];
  logic [SMP_W-1:0] res [N_CH];

  assign raw[0] = raw_l_i;
  assign raw[1] = raw_r_i;

  ocal_timer #(
    .BUSY_BASE (BUSY_BASE),
    .VALID_BASE(VALID_BASE),
    .AVG_N     (AVG_N)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (stb_i),
    .dbl_i   (dbl_rate_i),
    .slave_i (slave_i),
    .busy_o  (busy),
    .valid_o (valid),
    .acc_en_o(acc_en),
    .latch_o (latch),
    .load_o  (load)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ocal_chan #(.AVG_N(AVG_N)) i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (raw[c]),
      .acc_en_i(acc_en),
      .latch_i (latch),
      .load_i  (load),
      .hold_i  (valid),
      .out_o   (res[c])
    );
  end

  assign out_l_o  = res[0];
  assign out_r_o  = res[1];
  assign busy_o   = busy;
  assign valid_o  = valid;
  assign cm_sel_o = busy & ~cal_sig_i;

  // R9
  cm_sel_in_cal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_sel_o |-> busy_o);
  // R2
  busy_first_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !valid_o);
endmodule

// File: tb/test_ocal_seq.sv
module test_ocal_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0;
  logic        dbl = 1'b0;
  logic        slv = 1'b0;
  logic        sig = 1'b0;
  logic [23:0] raw_l = '0;
  logic [23:0] raw_r = '0;
  logic        cm_sel, busy, valid;
  logic [23:0] out_l, out_r;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ocal_seq i_ocal_seq (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .dbl_rate_i(dbl), .slave_i(slv),
    .cal_sig_i(sig), .raw_l_i(raw_l), .raw_r_i(raw_r), .cm_sel_o(cm_sel),
    .busy_o(busy), .valid_o(valid), .out_l_o(out_l), .out_r_o(out_r)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] sat(input longint raw, input longint off);
    longint d = raw - off;
    if (d > 64'sd8388607)  return 24'h7FFFFF;
    if (d < -64'sd8388608) return 24'h800000;
    return 24'(d);
  endfunction

  function automatic longint sx(input logic [23:0] v);
    return longint'($signed(v));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stb = 1'b1; raw_l = 24'h123456; raw_r = 24'h654321;
    @(negedge clk);
    // R1
    chk(busy == 0 && valid == 0 && cm_sel == 0, "R1 flags in reset", {busy, valid, cm_sel}, 0);
    chk(out_l == 0 && out_r == 0, "R1 outputs in reset", out_l, 0);
    stb = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2
    chk(busy == 1, "R2 busy after release", busy, 1);
    chk(cm_sel == !sig, "R9 front-end steer", cm_sel, !sig);
  endtask

  task automatic run_cal(input bit d, input bit s, input bit src,
                         input int bl_v, input int br_v, input string tag);
    int bl = (d ? 17408 : 8704) + int'(s);
    int vl = (d ? 17920 : 8960) + int'(s);
    logic [23:0] post [4];
    dbl = d; slv = s; sig = src;
    do_reset();
    for (int k = 1; k <= vl; k++) begin
      stb = 1'b1;
      if (k <= bl - 256) begin
        raw_l = 24'h400000; raw_r = 24'hC00000;
      end else if (k <= bl) begin
        raw_l = 24'(bl_v + (k % 4) - 1); raw_r = 24'(br_v + (k % 4) - 1);
      end else begin
        raw_l = 24'(bl_v + 5); raw_r = 24'(br_v - 7);
      end
      @(negedge clk);
      if (k == bl - 1) begin
        chk(busy == 1, {tag, " R3 R4 R5 busy before limit"}, busy, 1);
        chk(cm_sel == !src, {tag, " R9 steer in cal"}, cm_sel, !src);
      end
      if (k == bl) begin
        chk(busy == 0, {tag, " R3 R4 R5 busy at limit"}, busy, 0);
        chk(cm_sel == 0, {tag, " R9 steer after cal"}, cm_sel, 0);
      end
      if (k == vl - 1) begin
        chk(valid == 0, {tag, " R3 R4 R5 valid before limit"}, valid, 0);
        chk(out_l == 0 && out_r == 0, {tag, " R7 zero before valid"}, out_l, 0);
      end
      if (k == vl) begin
        chk(valid == 1, {tag, " R3 R4 R5 valid at limit"}, valid, 1);
        chk(out_l == 24'd5, {tag, " R6 left offset"}, out_l, 5);
        chk(out_r == 24'(-7), {tag, " R6 right offset"}, out_r, 24'(-7));
      end
    end
    post[0] = 24'h000000; post[1] = 24'h7FFFF0; post[2] = 24'h800010; post[3] = 24'h001234;
    for (int i = 0; i < 4; i++) begin
      stb = 1'b1; raw_l = post[i]; raw_r = post[3-i];
      @(negedge clk);
      chk(out_l == sat(sx(post[i]), bl_v), {tag, " R7 R8 left"}, out_l, sat(sx(post[i]), bl_v));
      chk(out_r == sat(sx(post[3-i]), br_v), {tag, " R7 R8 right"}, out_r,
          sat(sx(post[3-i]), br_v));
      stb = 1'b0; raw_l = 24'h555555; raw_r = 24'hAAAAAA;
      @(negedge clk);
      chk(out_l == sat(sx(post[i]), bl_v), {tag, " R7 hold"}, out_l, sat(sx(post[i]), bl_v));
      chk(valid == 1, {tag, " R7 valid sticky"}, valid, 1);
    end
  endtask

  task automatic run_abort();
    dbl = 1'b0; slv = 1'b0; sig = 1'b1;
    do_reset();
    for (int k = 1; k <= 4000; k++) begin
      stb = 1'b1; raw_l = 24'h000100; raw_r = 24'h000200;
      @(negedge clk);
    end
    stb = 1'b0;
    rst_n = 1'b0;
    #1;
    // R10
    chk(busy == 0 && valid == 0, "R10 busy cleared on abort", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1, "R10 busy again after release", busy, 1);
    for (int k = 1; k <= 8703; k++) begin
      stb = 1'b1;
      @(negedge clk);
    end
    stb = 1'b0;
    chk(busy == 1, "R10 count restarted from zero", busy, 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    run_cal(1'b0, 1'b0, 1'b1, 300, -4000, "norm_master");
    run_cal(1'b0, 1'b1, 1'b0, -1000, 1000, "norm_slave");
    run_cal(1'b1, 1'b0, 1'b0, 20, -20, "dbl_master");
    run_cal(1'b1, 1'b1, 1'b1, -77, 4096, "dbl_slave");
    run_abort();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule